// File: doc/BRIEF.md
# Sweep Parameter Register Interface

This block accepts 16-bit configuration words, one per write strobe, and loads them into the parameter registers that a frequency sweep engine reads. The four most significant bits of each word choose the destination register. The remaining bits carry the field value. The registers hold a 24-bit start frequency, a 23-bit increment magnitude with a direction flag, a 12-bit step count, and an 11-bit dwell count with a dwell-mode flag.

The start frequency has two update modes, chosen by the `pair_mode` input. In split mode each 12-bit half of the start frequency is written on its own. In paired mode the low half is staged in a shadow register. The visible 24-bit value then changes in a single cycle, at the moment the high half arrives. All parameter outputs come straight from registers, so the sweep engine always sees stable values.

Top module: `sweep_param_regs`

## Requirements
- R1: A word is accepted only in a cycle with `wr_en` high. Bits 15..12 of the word select the target register. Every update appears on the outputs one clock after the accepting edge, and not before that edge.
- R2: Address 0001 loads `step_count` from bits 11..0.
- R3: Address 0010 loads `incr_mag[11:0]` from bits 11..0. The high part of `incr_mag` and `incr_dir` are not changed.
- R4: Address 0011 loads `incr_mag[22:12]` from bits 10..0 and loads `incr_dir` from bit 11 (0 means add, 1 means subtract). `incr_mag[11:0]` is not changed.
- R5: Any address 01xx loads the dwell fields. `dwell_mode` is taken from bit 13 (0 counts output waveform cycles, 1 counts clock periods) and `dwell_count` from bits 10..0. Bits 12 and 11 have no effect.
- R6: With `pair_mode` = 0, address 1100 writes `start_freq[11:0]` and address 1101 writes `start_freq[23:12]` directly, and the other half keeps its value. A start write in this mode drops any staged low half.
- R7: With `pair_mode` = 1, an address 1100 write only stages the low half, and `start_freq` does not change. A later staged write replaces the earlier one. Writes to other registers in between do not drop the stage.
- R8: With `pair_mode` = 1 and a low half staged, an address 1101 write sets `start_freq` to {bits 11..0, staged low} in one cycle and clears the stage.
- R9: With `pair_mode` = 1 and nothing staged, an address 1101 write changes only `start_freq[23:12]`.
- R10: Words with addresses 0000, 1000 through 1011, 1110 and 1111 change no output. Words presented while `wr_en` is low also change no output.
- R11: Synchronous active-high `rst` clears every parameter output to zero and discards any staged low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per high cycle |
| wr_word | input | 16 | Configuration word |
| pair_mode | input | 1 | 1 = paired start-frequency update, 0 = split |
| start_freq | output | 24 | Start frequency |
| incr_mag | output | 23 | Increment magnitude |
| incr_dir | output | 1 | 0 = add increment, 1 = subtract |
| step_count | output | 12 | Number of increments |
| dwell_count | output | 11 | Dwell length per step |
| dwell_mode | output | 1 | 0 = waveform cycles, 1 = clock periods |

## Verification
Every result of this block is due exactly one rising edge after the word is accepted, because each field passes through a single register. The bench presents words on falling edges and samples on the next falling edge, so each comparison lands half a period after the edge that produces the result. One directed test samples just before that edge to confirm that the old value is still present. Staged paired-mode writes are checked at the same point, and there `start_freq` must not have moved.

// File: rtl/sweep_cfg_pkg.sv
package sweep_cfg_pkg;

  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int FIELD_W = 12;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_STEP,
    TGT_INC_LO,
    TGT_INC_HI,
    TGT_DWELL,
    TGT_START_LO,
    TGT_START_HI
  } tgt_e;

  function automatic tgt_e decode_addr(input logic [ADDR_W-1:0] a);
    tgt_e t;
    casez (a)
      4'b0001: t = TGT_STEP;
      4'b0010: t = TGT_INC_LO;
      4'b0011: t = TGT_INC_HI;
      4'b01??: t = TGT_DWELL;
      4'b1100: t = TGT_START_LO;
      4'b1101: t = TGT_START_HI;
      default: t = TGT_NONE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sweep_word_decoder.sv
module sweep_word_decoder
  import sweep_cfg_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int AW = ADDR_W,
  parameter int FW = FIELD_W
) (
  input  logic          wr_en,
  input  logic [WW-1:0] word,
  output tgt_e          tgt,
  output logic [FW-1:0] payload
);

  always_comb begin
    tgt     = wr_en ? decode_addr(word[WW-1 -: AW]) : TGT_NONE;
    payload = word[FW-1:0];
  end

endmodule

// File: rtl/sweep_field_reg.sv
module sweep_field_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_FIELD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R10

endmodule

// File: rtl/sweep_start_reg.sv
module sweep_start_reg #(
  parameter int HALF_W = 12,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_mode,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] d,
  output logic [FULL_W-1:0] q
);

  logic [HALF_W-1:0] shadow;
  logic              staged;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      shadow <= '0;
      staged <= 1'b0;
    end else if (pair_mode) begin
      if (ld_lo) begin
        shadow <= d;
        staged <= 1'b1;
      end else if (ld_hi) begin
        q[FULL_W-1:HALF_W] <= d;
        if (staged) q[HALF_W-1:0] <= shadow;
        staged <= 1'b0;
      end
    end else begin
      if (ld_lo) begin
        q[HALF_W-1:0] <= d;
        staged        <= 1'b0;
      end else if (ld_hi) begin
        q[FULL_W-1:HALF_W] <= d;
        staged             <= 1'b0;
      end
    end
  end

  AST_PAIR_LO_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && pair_mode) |=> $stable(q)); // R7
  AST_HI_CLEARS_STAGE: assert property (@(posedge clk) disable iff (rst)
    ld_hi |=> !staged); // R8
  AST_SPLIT_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !pair_mode) |=> q[HALF_W-1:0] == $past(q[HALF_W-1:0])); // R6
  AST_SPLIT_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !pair_mode) |=> q[FULL_W-1:HALF_W] == $past(q[FULL_W-1:HALF_W])); // R6

endmodule

// File: rtl/sweep_param_regs.sv
module sweep_param_regs
  import sweep_cfg_pkg::*;
#(
  parameter int STEP_W  = 12,
  parameter int INC_W   = 23,
  parameter int DWELL_W = 11,
  localparam int START_W = 2 * FIELD_W,
  localparam int INC_HI_W = INC_W - FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               pair_mode,
  output logic [START_W-1:0] start_freq,
  output logic [INC_W-1:0]   incr_mag,
  output logic               incr_dir,
  output logic [STEP_W-1:0]  step_count,
  output logic [DWELL_W-1:0] dwell_count,
  output logic               dwell_mode
);

  tgt_e               tgt;
  logic [FIELD_W-1:0] payload;
  logic [FIELD_W-1:0] inc_hi_q;
  logic [DWELL_W:0]   dwell_q;

  sweep_word_decoder u_dec (
    .wr_en   (wr_en),
    .word    (wr_word),
    .tgt     (tgt),
    .payload (payload)
  );

  sweep_field_reg #(.W(STEP_W)) u_step (
    .clk (clk), .rst (rst), .load (tgt == TGT_STEP),
    .d   (payload[STEP_W-1:0]), .q (step_count)
  );

  sweep_field_reg #(.W(FIELD_W)) u_inc_lo (
    .clk (clk), .rst (rst), .load (tgt == TGT_INC_LO),
    .d   (payload), .q (incr_mag[FIELD_W-1:0])
  );

  sweep_field_reg #(.W(FIELD_W)) u_inc_hi (
    .clk (clk), .rst (rst), .load (tgt == TGT_INC_HI),
    .d   (payload), .q (inc_hi_q)
  );

  sweep_field_reg #(.W(DWELL_W + 1)) u_dwell (
    .clk (clk), .rst (rst), .load (tgt == TGT_DWELL),
    .d   ({wr_word[13], wr_word[DWELL_W-1:0]}), .q (dwell_q)
  );

  sweep_start_reg #(.HALF_W(FIELD_W)) u_start (
    .clk       (clk),
    .rst       (rst),
    .pair_mode (pair_mode),
    .ld_lo     (tgt == TGT_START_LO),
    .ld_hi     (tgt == TGT_START_HI),
    .d         (payload),
    .q         (start_freq)
  );

  assign incr_mag[INC_W-1:FIELD_W] = inc_hi_q[INC_HI_W-1:0];
  assign incr_dir    = inc_hi_q[FIELD_W-1];
  assign dwell_mode  = dwell_q[DWELL_W];
  assign dwell_count = dwell_q[DWELL_W-1:0];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (start_freq == '0 && incr_mag == '0 && !incr_dir &&
                    step_count == '0 && dwell_count == '0 && !dwell_mode)); // R11
  AST_STEP_ONLY_ON_ADDR: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_word[15:12] == 4'b0001) |=> $stable(step_count)); // R2
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(start_freq) && $stable(incr_mag) && $stable(incr_dir) &&
                $stable(step_count) && $stable(dwell_count) && $stable(dwell_mode))); // R10
  AST_INC_HI_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word[15:12] == 4'b0011) |=> incr_dir == $past(wr_word[11])); // R4

endmodule

// File: tb/sweep_param_regs_test.sv
`timescale 1ns/1ps
module sweep_param_regs_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_word;
  logic        pair_mode;
  logic [23:0] start_freq;
  logic [22:0] incr_mag;
  logic        incr_dir;
  logic [11:0] step_count;
  logic [10:0] dwell_count;
  logic        dwell_mode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sweep_param_regs uut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_word (wr_word),
    .pair_mode (pair_mode), .start_freq (start_freq), .incr_mag (incr_mag),
    .incr_dir (incr_dir), .step_count (step_count),
    .dwell_count (dwell_count), .dwell_mode (dwell_mode)
  );

  // {start24, dir1, incr23, step12, mode1, dwell11} = 72 bits
  function automatic logic [71:0] pack(logic [23:0] s, logic d, logic [22:0] i,
                                       logic [11:0] st, logic m, logic [10:0] dw);
    return {s, d, i, st, m, dw};
  endfunction

  function automatic logic [71:0] outs();
    return {start_freq, incr_dir, incr_mag, step_count, dwell_mode, dwell_count};
  endfunction

  task automatic check(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: {req[7:0], pair, word[15:0], expected[71:0]}
  localparam int NV = 22;
  localparam logic [96:0] VEC [NV] = '{
    {8'd2,  1'b0, 16'h1ABC, 24'h000000, 1'b0, 23'h000000, 12'hABC, 1'b0, 11'h000}, // R2
    {8'd3,  1'b0, 16'h2123, 24'h000000, 1'b0, 23'h000123, 12'hABC, 1'b0, 11'h000}, // R3
    {8'd4,  1'b0, 16'h3FFF, 24'h000000, 1'b1, 23'h7FF123, 12'hABC, 1'b0, 11'h000}, // R4
    {8'd4,  1'b0, 16'h3255, 24'h000000, 1'b0, 23'h255123, 12'hABC, 1'b0, 11'h000}, // R4
    {8'd3,  1'b0, 16'h2FED, 24'h000000, 1'b0, 23'h255FED, 12'hABC, 1'b0, 11'h000}, // R3
    {8'd5,  1'b0, 16'h4A05, 24'h000000, 1'b0, 23'h255FED, 12'hABC, 1'b0, 11'h205}, // R5
    {8'd5,  1'b0, 16'h7FFF, 24'h000000, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h7FF}, // R5
    {8'd5,  1'b0, 16'h6003, 24'h000000, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R5
    {8'd6,  1'b0, 16'hC456, 24'h000456, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R6
    {8'd6,  1'b0, 16'hD789, 24'h789456, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R6
    {8'd6,  1'b0, 16'hC111, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R6
    {8'd10, 1'b0, 16'h0FFF, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R10
    {8'd10, 1'b0, 16'h8FFF, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R10
    {8'd10, 1'b0, 16'hBFFF, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R10
    {8'd10, 1'b0, 16'hEFFF, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R10
    {8'd10, 1'b1, 16'hFFFF, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R10
    {8'd7,  1'b1, 16'hCAAA, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R7
    {8'd7,  1'b1, 16'hCBBB, 24'h789111, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R7
    {8'd8,  1'b1, 16'hDCCC, 24'hCCCBBB, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R8
    {8'd9,  1'b1, 16'hDDDD, 24'hDDDBBB, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R9
    {8'd7,  1'b1, 16'hC222, 24'hDDDBBB, 1'b0, 23'h255FED, 12'hABC, 1'b1, 11'h003}, // R7
    {8'd7,  1'b1, 16'h1005, 24'hDDDBBB, 1'b0, 23'h255FED, 12'h005, 1'b1, 11'h003}  // R7 stage kept
  };

  task automatic write(logic pm, logic [15:0] w);
    pair_mode = pm;
    wr_word   = w;
    wr_en     = 1'b1;
    @(negedge clk);
    wr_en     = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [71:0] expv;
    rst = 1'b1; wr_en = 1'b0; wr_word = '0; pair_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset state", outs(), 72'h0);

    for (int k = 0; k < NV; k++) begin
      write(VEC[k][88], VEC[k][87:72]);
      check($sformatf("R%0d vector %0d", VEC[k][96:89], k), outs(), VEC[k][71:0]);
    end

    // R8: commit after intervening write
    write(1'b1, 16'hD333);
    expv = pack(24'h333222, 1'b0, 23'h255FED, 12'h005, 1'b1, 11'h003);
    check("R8 commit after other write", outs(), expv);

    // R10: wr_en low ignored
    wr_word = 16'h1FFF; pair_mode = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R10 strobe low ignored", outs(), expv);

    // R1: value changes only after the accepting edge
    wr_word = 16'h1777; wr_en = 1'b1;
    #1.5;
    check("R1 not before edge", outs(), expv);
    @(negedge clk);
    wr_en = 1'b0;
    expv = pack(24'h333222, 1'b0, 23'h255FED, 12'h777, 1'b1, 11'h003);
    check("R1 one clock after edge", outs(), expv);

    // R6: split start write drops a staged low half
    write(1'b1, 16'hC999);
    write(1'b0, 16'hD444);
    expv = pack(24'h444222, 1'b0, 23'h255FED, 12'h777, 1'b1, 11'h003);
    check("R6 split high write", outs(), expv);
    write(1'b1, 16'hD555);
    expv = pack(24'h555222, 1'b0, 23'h255FED, 12'h777, 1'b1, 11'h003);
    check("R6 stage dropped by split write", outs(), expv);

    // R11: reset discards a staged low half
    write(1'b1, 16'hC888);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset mid stage", outs(), 72'h0);
    write(1'b1, 16'hD666);
    expv = pack(24'h666000, 1'b0, 23'h0, 12'h0, 1'b0, 11'h0);
    check("R11 stage cleared by reset", outs(), expv);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule